// File: doc/BRIEF.md
# STN Color Lookup Table Mapper

The mapper turns a pixel index into three 6-bit channel intensities for a passive-matrix color panel. It holds three packed tables of 4-bit levels: a red table and a green table of eight levels each (32 bits), and a blue table of four levels (16 bits). Software loads each table as a whole word through a simple write port.

Two mapping modes exist. In split mode, the 8-bit index is divided into three fields: the top three bits choose a red level, the middle three choose a green level and the low two choose a blue level, each from its own table. In small-index mode, one index value chooses the same level position in all three tables. A position that a table does not have gives zero for that channel. The chosen 4-bit level is widened to 6 bits by appending two zero bits. The result is registered and is marked by a valid flag one cycle after the request.

Top module: `clut_mapper`

## Requirements
- R1: After synchronous reset, out_valid is 0, all three channel outputs are 0, and all three tables hold zero, so any lookup returns 0 on every channel.
- R2: With map_mode = 1 (split mode), index bits [7:5] give a number n from 0 to 7, and out_red comes from red-table bits [4n+3:4n].
- R3: With map_mode = 1, index bits [4:2] give a number n from 0 to 7, and out_green comes from green-table bits [4n+3:4n].
- R4: With map_mode = 1, index bits [1:0] give a number n from 0 to 3, and out_blue comes from blue-table bits [4n+3:4n] of the 16-bit blue table.
- R5: With map_mode = 0 (small-index mode), index i chooses level i of every table. Red and green are 0 when i >= 8, and blue is 0 when i >= 4.
- R6: Each channel output equals the chosen 4-bit level shifted left by two, so its two low bits are always 0.
- R7: out_valid is 1 exactly in the cycle after a cycle with in_valid = 1, and back-to-back requests give back-to-back results. When in_valid is 0, the channel outputs keep their last values.
- R8: With wr_en = 1, wr_sel = 0 loads wr_data into the red table, wr_sel = 1 loads it into the green table, wr_sel = 2 loads wr_data[15:0] into the blue table, and wr_sel = 3 changes nothing. A write is seen by lookups requested in the next cycle or later. A lookup requested in the same cycle as the write uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Table choice: 0 red, 1 green, 2 blue, 3 none |
| wr_data | input | 32 | Packed levels to load into the chosen table |
| in_valid | input | 1 | Lookup request |
| map_mode | input | 1 | 1 = split mode, 0 = small-index mode |
| in_index | input | 8 | Pixel index |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_red | output | 6 | Red intensity |
| out_green | output | 6 | Green intensity |
| out_blue | output | 6 | Blue intensity |

## Verification
All 256 index values are tried in both modes, with two table sets whose level values differ at every position. Each table's levels therefore identify the position they came from, and a swapped field or a wrong field boundary shows up as a wrong level. The small-index sweep runs past positions 3 and 7, which separates correct zeroing from wrap-around or reuse of the low index bits. Dedicated sequences check a write in the same cycle as a lookup, a write to the unused table choice, back-to-back requests and output hold while idle. These show whether the write timing, the write decoding and the valid pipeline are right.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    TBL_RED   = 2'd0,
    TBL_GREEN = 2'd1,
    TBL_BLUE  = 2'd2,
    TBL_NONE  = 2'd3
  } tbl_id_e;
endpackage

// File: rtl/clut_table_reg.sv
module clut_table_reg
  import clut_pkg::*;
#(
  parameter int      DATA_W = 32,
  parameter int      TBL_W  = 32,
  parameter tbl_id_e MY_ID  = TBL_RED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TBL_W-1:0]  tbl
);
  logic hit;
  assign hit = wr_en && (wr_sel == MY_ID);

  always_ff @(posedge clk) begin
    if (rst) tbl <= '0;
    else if (hit) tbl <= wr_data[TBL_W-1:0];
  end

  assert_table_load_R8: assert property (@(posedge clk) disable iff (rst)
    hit |=> tbl == $past(wr_data[TBL_W-1:0]));
  assert_table_keep_R8: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(tbl));
endmodule

// File: rtl/clut_index_split.sv
module clut_index_split #(
  parameter int IDX_W  = 8,
  parameter int RG_SW  = 3,
  parameter int B_SW   = 2
) (
  input  logic             split_mode,
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] sel_r,
  output logic [IDX_W-1:0] sel_g,
  output logic [IDX_W-1:0] sel_b
);
  localparam int G_LO = B_SW;
  localparam int R_LO = B_SW + RG_SW;

  always_comb begin
    if (split_mode) begin
      sel_r = IDX_W'(idx[R_LO +: RG_SW]);
      sel_g = IDX_W'(idx[G_LO +: RG_SW]);
      sel_b = IDX_W'(idx[0 +: B_SW]);
    end else begin
      sel_r = idx;
      sel_g = idx;
      sel_b = idx;
    end
  end
endmodule

// File: rtl/clut_nibble_sel.sv
module clut_nibble_sel #(
  parameter int NIBS  = 8,
  parameter int NIB_W = 4,
  parameter int IDX_W = 8,
  parameter int CH_W  = 6
) (
  input  logic [NIBS*NIB_W-1:0] tbl,
  input  logic [IDX_W-1:0]      sel,
  output logic [CH_W-1:0]       level
);
  localparam int PAD = CH_W - NIB_W;
  logic [NIB_W-1:0] nib;

  always_comb begin
    nib = '0;
    for (int k = 0; k < NIBS; k++) begin
      if (sel == IDX_W'(k)) nib = tbl[k*NIB_W +: NIB_W];
    end
    level = {nib, {PAD{1'b0}}};
  end
endmodule

// File: rtl/clut_mapper.sv
module clut_mapper
  import clut_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int NIB_W   = 4,
  parameter int RG_NIBS = 8,
  parameter int B_NIBS  = 4,
  parameter int CH_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [RG_NIBS*NIB_W-1:0] wr_data,
  input  logic                     in_valid,
  input  logic                     map_mode,
  input  logic [IDX_W-1:0]         in_index,
  output logic                     out_valid,
  output logic [CH_W-1:0]          out_red,
  output logic [CH_W-1:0]          out_green,
  output logic [CH_W-1:0]          out_blue
);
  localparam int RG_TW = RG_NIBS * NIB_W;
  localparam int B_TW  = B_NIBS * NIB_W;
  localparam int RG_SW = $clog2(RG_NIBS);
  localparam int B_SW  = $clog2(B_NIBS);
  localparam int PAD   = CH_W - NIB_W;

  logic [RG_TW-1:0] tbl_r, tbl_g;
  logic [B_TW-1:0]  tbl_b;
  logic [IDX_W-1:0] sel_r, sel_g, sel_b;
  logic [CH_W-1:0]  lvl_r, lvl_g, lvl_b;

  clut_table_reg #(.DATA_W(RG_TW), .TBL_W(RG_TW), .MY_ID(TBL_RED)) u_tbl_r (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .tbl(tbl_r));
  clut_table_reg #(.DATA_W(RG_TW), .TBL_W(RG_TW), .MY_ID(TBL_GREEN)) u_tbl_g (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .tbl(tbl_g));
  clut_table_reg #(.DATA_W(RG_TW), .TBL_W(B_TW), .MY_ID(TBL_BLUE)) u_tbl_b (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .tbl(tbl_b));

  clut_index_split #(.IDX_W(IDX_W), .RG_SW(RG_SW), .B_SW(B_SW)) u_split (
    .split_mode(map_mode), .idx(in_index),
    .sel_r(sel_r), .sel_g(sel_g), .sel_b(sel_b));

  clut_nibble_sel #(.NIBS(RG_NIBS), .NIB_W(NIB_W), .IDX_W(IDX_W), .CH_W(CH_W)) u_sel_r (
    .tbl(tbl_r), .sel(sel_r), .level(lvl_r));
  clut_nibble_sel #(.NIBS(RG_NIBS), .NIB_W(NIB_W), .IDX_W(IDX_W), .CH_W(CH_W)) u_sel_g (
    .tbl(tbl_g), .sel(sel_g), .level(lvl_g));
  clut_nibble_sel #(.NIBS(B_NIBS), .NIB_W(NIB_W), .IDX_W(IDX_W), .CH_W(CH_W)) u_sel_b (
    .tbl(tbl_b), .sel(sel_b), .level(lvl_b));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_red   <= '0;
      out_green <= '0;
      out_blue  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_red   <= lvl_r;
        out_green <= lvl_g;
        out_blue  <= lvl_b;
      end
    end
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_red) && $stable(out_green) && $stable(out_blue)));
  assert_low_bits_zero_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_red[PAD-1:0] == '0 && out_green[PAD-1:0] == '0
                   && out_blue[PAD-1:0] == '0));
  assert_small_blue_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !map_mode && in_index >= IDX_W'(B_NIBS)) |=> out_blue == '0);
  assert_small_rg_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !map_mode && in_index >= IDX_W'(RG_NIBS)) |=>
      (out_red == '0 && out_green == '0));
endmodule

// File: tb/clut_mapper_tb.sv
`timescale 1ns/1ps
module clut_mapper_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic in_valid = 1'b0;
  logic map_mode = 1'b0;
  logic [7:0] in_index = '0;
  logic out_valid;
  logic [5:0] out_red, out_green, out_blue;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] mr = '0, mg = '0;
  logic [15:0] mb = '0;

  always #2.5 clk = ~clk;

  clut_mapper dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .in_valid(in_valid), .map_mode(map_mode), .in_index(in_index),
    .out_valid(out_valid), .out_red(out_red), .out_green(out_green), .out_blue(out_blue));

  function automatic logic [5:0] lvl(input logic [31:0] t, input int nibs, input int s);
    if (s >= nibs) return 6'd0;
    return {4'((t >> (4 * s)) & 32'hF), 2'b00};
  endfunction

  function automatic logic [17:0] expect_rgb(input logic m, input logic [7:0] idx);
    int sr, sg, sb;
    if (m) begin sr = idx[7:5]; sg = idx[4:2]; sb = idx[1:0]; end
    else begin sr = idx; sg = idx; sb = idx; end
    return {lvl(mr, 8, sr), lvl(mg, 8, sg), lvl({16'h0, mb}, 4, sb)};
  endfunction

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b rgb=%h expected v=%0b rgb=%h",
               tag, act[18], act[17:0], exp[18], exp[17:0]);
    end
  endtask

  task automatic lookup(input logic m, input logic [7:0] idx, input string tag);
    @(negedge clk);
    in_valid = 1'b1; map_mode = m; in_index = idx;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, out_red, out_green, out_blue}, {1'b1, expect_rgb(m, idx)});
  endtask

  task automatic write_tbl(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (s)
      2'd0: mr = d;
      2'd1: mg = d;
      2'd2: mb = d[15:0];
      default: ;
    endcase
  endtask

  task automatic sweeps();
    for (int i = 0; i < 256; i++) lookup(1'b1, 8'(i), "split mode R2 R3 R4 R6");
    for (int i = 0; i < 256; i++) lookup(1'b0, 8'(i), "small-index mode R5 R6");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [18:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("reset outputs R1", {out_valid, out_red, out_green, out_blue}, 19'd0);
    lookup(1'b1, 8'hFF, "reset tables R1");
    lookup(1'b0, 8'h02, "reset tables R1");

    write_tbl(2'd0, 32'h7654_3210);
    write_tbl(2'd1, 32'hFEDC_BA98);
    write_tbl(2'd2, 32'hAAAA_5A3C);
    sweeps();

    write_tbl(2'd0, 32'h9E1F_0C7B);
    write_tbl(2'd1, 32'h2468_ACE1);
    write_tbl(2'd2, 32'h0000_F0D2);
    sweeps();

    // R8: unused table choice changes nothing
    write_tbl(2'd3, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) lookup(1'b0, 8'(i), "wr_sel 3 ignored R8");

    // R8: write and lookup in the same cycle see the old contents
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h5000_0000;
    in_valid = 1'b1; map_mode = 1'b1; in_index = 8'hE0;
    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b0;
    check("same-cycle write uses old table R8",
          {out_valid, out_red, out_green, out_blue}, {1'b1, expect_rgb(1'b1, 8'hE0)});
    mr = 32'h5000_0000;
    lookup(1'b1, 8'hE0, "write seen next cycle R8");

    // R7: back-to-back and idle hold
    @(negedge clk);
    in_valid = 1'b1; map_mode = 1'b1; in_index = 8'h00;
    @(negedge clk);
    check("back-to-back first R7", {out_valid, out_red, out_green, out_blue},
          {1'b1, expect_rgb(1'b1, 8'h00)});
    in_index = 8'h6D;
    @(negedge clk);
    in_valid = 1'b0;
    check("back-to-back second R7", {out_valid, out_red, out_green, out_blue},
          {1'b1, expect_rgb(1'b1, 8'h6D)});
    held = {1'b0, expect_rgb(1'b1, 8'h6D)};
    in_index = 8'h00;
    @(negedge clk);
    check("idle drops valid and holds data R7",
          {out_valid, out_red, out_green, out_blue}, held);
    @(negedge clk);
    check("idle hold second cycle R7",
          {out_valid, out_red, out_green, out_blue}, held);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule